// File: doc/BRIEF.md
# Mobile DDR Power-On Initialization Sequencer

This block brings a low-power DDR memory from power-up to a usable state. After reset it holds the command bus deselected with the clock enable high for a configurable startup pause. It then issues a precharge of every bank, a parameterized number of auto-refresh commands, a write of the mode register and a write of the extended mode register, and finally raises a completion flag. Every gap between commands is a parameter given in nanoseconds and turned into clock cycles from the clock period.

The mode register values come from configuration inputs: burst length, wrap type and CAS latency for the main register, and partial-array self-refresh, temperature-compensated self-refresh and drive strength for the extended register. The configuration is captured in the cycle the precharge goes out. Reserved codes are replaced by safe defaults and an error flag is raised. A `start` pulse after completion runs the whole sequence again, including the pause, for example after the memory leaves deep power-down.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is asserted, `cke` is 1, the command bus {cs_n,ras_n,cas_n,we_n} is 1111 (deselect), `ba` and `addr` are 0, and `init_done` and `config_error` are 0.
- R2: After reset release, the bus stays deselected until clock edge PAUSE (PAUSE = ceil(POWERUP_NS*1000/CLK_PERIOD_PS)). At that edge a precharge-all goes out: bus 0010 with `addr[10]`=1 and every other address bit and `ba` 0.
- R3: After the precharge, the bus carries NOP (0111) with `addr` and `ba` at 0 until the first auto-refresh, which comes exactly TRP_CYC cycles later.
- R4: NUM_REFRESH auto-refresh commands (bus 0001, `addr` and `ba` 0) go out, each TRFC_CYC cycles after the one before, with NOP in between.
- R5: TRFC_CYC cycles after the last refresh, the mode register is written: bus 0000, `ba`=00. `addr[2:0]` is the burst length (001=2, 010=4, 011=8), `addr[3]` is the wrap type (0 sequential, 1 interleave), `addr[6:4]` is the CAS latency (010=2, 011=3), and the upper bits are 0.
- R6: TMRD_CYC cycles later (at least 2), the extended register is written: bus 0000, `ba`=10 (`ba[1]`=1). `addr[2:0]` is the self-refresh array coverage (000 all, 001 two banks, 010 one bank, 101 half bank, 110 quarter bank), `addr[4:3]` is the self-refresh temperature code, `addr[6:5]` is the drive strength, and the upper bits are 0.
- R7: TMRD_CYC cycles after the extended write, `init_done` rises. It stays high, with NOP on the bus, until a start is accepted.
- R8: Reserved codes are replaced: burst length 000 or 1xx becomes 010, CAS latency other than 010/011 becomes 011, array coverage 011/100/111 becomes 000. `config_error` is loaded at the precharge edge: 1 if any code was replaced, else 0.
- R9: Configuration changes after the precharge edge have no effect on the words written in that run.
- R10: A `start` pulse while `init_done` is high clears `init_done`, deselects the bus and reruns the sequence from the pause. The precharge comes PAUSE edges after the accepting edge. A `start` during a running sequence has no effect.
- R11: `cke` stays 1 at all times.
- R12: Each gap parameter in ns becomes ceil(ns*1000/CLK_PERIOD_PS) cycles, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to rerun the sequence after completion |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_wrap | input | 1 | Wrap type, 1 = interleave |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_pasr | input | 3 | Self-refresh array coverage code |
| cfg_tcsr | input | 2 | Self-refresh temperature code |
| cfg_drive | input | 2 | Output drive strength code |
| cke | output | 1 | Clock enable to memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address, selects the mode register |
| addr | output | ADDR_W | Address bus carrying A10 and the register words |
| init_done | output | 1 | Sequence complete |
| config_error | output | 1 | A reserved configuration code was replaced |

## Verification
The assertions assume the synchronous reset is held for at least one clock edge, and that `start` is a plain level sampled on rising edges whose effect depends only on `init_done`. Configuration inputs may change at any time, because the design copies them once, at the precharge edge. The bench changes its inputs only on falling edges. It pulses `start` both during a running sequence and after completion, and it moves the configuration just after the precharge. The tMRD and NOP properties also assume the default cycle limits hold, TMRD_CYC of 2 or more and non-zero refresh counts, and the bench keeps to these.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

    // Command encoding on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_DESL = 4'b1111,
        CMD_NOP  = 4'b0111,
        CMD_PRE  = 4'b0010,
        CMD_REF  = 4'b0001,
        CMD_MODE = 4'b0000
    } cmd_e;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_GAP,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        STEP_PRE,
        STEP_REF,
        STEP_MRS,
        STEP_EMRS
    } step_e;

    // Bank-address selects for the two mode registers
    localparam logic [1:0] BA_MAIN = 2'b00;
    localparam logic [1:0] BA_EXT  = 2'b10;

    // Round a time in ns up to whole clock cycles, never below floor_cyc
    function automatic int ns_to_cyc(input longint ns, input longint period_ps,
                                     input int floor_cyc);
        longint c;
        c = (ns * 64'd1000 + period_ps - 64'd1) / period_ps;
        if (c < longint'(floor_cyc)) c = longint'(floor_cyc);
        return int'(c);
    endfunction

endpackage

// File: rtl/dinit_timer.sv
module dinit_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired); // R12

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!expired && !load) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R12

endmodule

// File: rtl/dinit_mode_word.sv
module dinit_mode_word #(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_wrap,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [2:0]        cfg_pasr,
    input  logic [1:0]        cfg_tcsr,
    input  logic [1:0]        cfg_drive,
    output logic [ADDR_W-1:0] main_word,
    output logic [ADDR_W-1:0] ext_word,
    output logic              cfg_bad
);
    localparam int FIELD_W = 7;
    localparam int PAD_W   = ADDR_W - FIELD_W;

    localparam logic [2:0] BL_SAFE   = 3'b010;
    localparam logic [2:0] CL_SAFE   = 3'b011;
    localparam logic [2:0] PASR_SAFE = 3'b000;

    logic [2:0] bl_ok, cl_ok, pasr_ok;
    logic       bl_bad, cl_bad, pasr_bad;

    always_comb begin
        unique case (cfg_burst_len)
            3'b001, 3'b010, 3'b011: bl_bad = 1'b0;
            default:                bl_bad = 1'b1;
        endcase
        unique case (cfg_cas_lat)
            3'b010, 3'b011: cl_bad = 1'b0;
            default:        cl_bad = 1'b1;
        endcase
        unique case (cfg_pasr)
            3'b000, 3'b001, 3'b010, 3'b101, 3'b110: pasr_bad = 1'b0;
            default:                                pasr_bad = 1'b1;
        endcase
        bl_ok   = bl_bad   ? BL_SAFE   : cfg_burst_len;
        cl_ok   = cl_bad   ? CL_SAFE   : cfg_cas_lat;
        pasr_ok = pasr_bad ? PASR_SAFE : cfg_pasr;
    end

    assign main_word = {{PAD_W{1'b0}}, cl_ok, cfg_wrap, bl_ok};
    assign ext_word  = {{PAD_W{1'b0}}, cfg_drive, cfg_tcsr, pasr_ok};
    assign cfg_bad   = bl_bad | cl_bad | pasr_bad;

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dinit_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int POWERUP_NS    = 200000,
    parameter int TRP_NS        = 30,
    parameter int TRFC_NS       = 110,
    parameter int TMRD_CYC      = 2,
    parameter int NUM_REFRESH   = 2,
    parameter int ADDR_W        = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_wrap,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [2:0]        cfg_pasr,
    input  logic [1:0]        cfg_tcsr,
    input  logic [1:0]        cfg_drive,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done,
    output logic              config_error
);
    localparam int PAUSE_CYC = ns_to_cyc(POWERUP_NS, CLK_PERIOD_PS, 1);
    localparam int TRP_CYC   = ns_to_cyc(TRP_NS, CLK_PERIOD_PS, 1);
    localparam int TRFC_CYC  = ns_to_cyc(TRFC_NS, CLK_PERIOD_PS, 1);
    localparam int MRD_CYC   = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
    localparam int MAX_A     = (PAUSE_CYC > TRFC_CYC) ? PAUSE_CYC : TRFC_CYC;
    localparam int MAX_B     = (TRP_CYC > MRD_CYC) ? TRP_CYC : MRD_CYC;
    localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int NREF      = (NUM_REFRESH < 1) ? 1 : NUM_REFRESH;
    localparam int REF_W     = (NREF > 1) ? $clog2(NREF) : 1;
    localparam int A10       = 10;

    typedef struct packed {
        phase_e            phase;
        step_e             step;
        logic [REF_W-1:0]  ref_idx;
        cmd_e              cmd;
        logic [1:0]        ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic              cfg_err;
        logic [ADDR_W-1:0] main_w;
        logic [ADDR_W-1:0] ext_w;
    } seq_t;

    seq_t s_d, s_q;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic [ADDR_W-1:0] main_word, ext_word;
    logic              cfg_bad;

    dinit_mode_word #(.ADDR_W(ADDR_W)) u_word (
        .cfg_burst_len (cfg_burst_len),
        .cfg_wrap      (cfg_wrap),
        .cfg_cas_lat   (cfg_cas_lat),
        .cfg_pasr      (cfg_pasr),
        .cfg_tcsr      (cfg_tcsr),
        .cfg_drive     (cfg_drive),
        .main_word     (main_word),
        .ext_word      (ext_word),
        .cfg_bad       (cfg_bad)
    );

    dinit_timer #(.CNT_W(CNT_W), .RST_VAL(PAUSE_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        s_d.ba   = '0;
        s_d.addr = '0;
        unique case (s_q.phase)
            PH_PAUSE: begin
                s_d.cmd = CMD_DESL;
                if (tmr_exp) begin
                    // precharge all banks and freeze the configuration
                    s_d.cmd       = CMD_PRE;
                    s_d.addr[A10] = 1'b1;
                    s_d.step      = STEP_PRE;
                    s_d.phase     = PH_GAP;
                    s_d.main_w    = main_word;
                    s_d.ext_w     = ext_word;
                    s_d.cfg_err   = cfg_bad;
                    tmr_load      = 1'b1;
                    tmr_val       = CNT_W'(TRP_CYC - 1);
                end
            end
            PH_GAP: begin
                s_d.cmd = CMD_NOP;
                if (tmr_exp) begin
                    unique case (s_q.step)
                        STEP_PRE: begin
                            s_d.cmd     = CMD_REF;
                            s_d.step    = STEP_REF;
                            s_d.ref_idx = '0;
                            tmr_load    = 1'b1;
                            tmr_val     = CNT_W'(TRFC_CYC - 1);
                        end
                        STEP_REF: begin
                            if (s_q.ref_idx == REF_W'(NREF - 1)) begin
                                s_d.cmd  = CMD_MODE;
                                s_d.ba   = BA_MAIN;
                                s_d.addr = s_q.main_w;
                                s_d.step = STEP_MRS;
                                tmr_load = 1'b1;
                                tmr_val  = CNT_W'(MRD_CYC - 1);
                            end else begin
                                s_d.cmd     = CMD_REF;
                                s_d.ref_idx = s_q.ref_idx + 1'b1;
                                tmr_load    = 1'b1;
                                tmr_val     = CNT_W'(TRFC_CYC - 1);
                            end
                        end
                        STEP_MRS: begin
                            s_d.cmd  = CMD_MODE;
                            s_d.ba   = BA_EXT;
                            s_d.addr = s_q.ext_w;
                            s_d.step = STEP_EMRS;
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(MRD_CYC - 1);
                        end
                        default: begin
                            s_d.phase = PH_DONE;
                            s_d.done  = 1'b1;
                        end
                    endcase
                end
            end
            default: begin
                s_d.cmd = CMD_NOP;
                if (start) begin
                    s_d.phase = PH_PAUSE;
                    s_d.done  = 1'b0;
                    s_d.cmd   = CMD_DESL;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(PAUSE_CYC - 1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase   <= PH_PAUSE;
            s_q.step    <= STEP_PRE;
            s_q.ref_idx <= '0;
            s_q.cmd     <= CMD_DESL;
            s_q.ba      <= '0;
            s_q.addr    <= '0;
            s_q.done    <= 1'b0;
            s_q.cfg_err <= 1'b0;
            s_q.main_w  <= '0;
            s_q.ext_w   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cke                        = 1'b1;
    assign {cs_n, ras_n, cas_n, we_n} = s_q.cmd;
    assign ba                         = s_q.ba;
    assign addr                       = s_q.addr;
    assign init_done                  = s_q.done;
    assign config_error               = s_q.cfg_err;

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == CMD_PRE) |-> addr[A10]); // R2

    AST_MODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == CMD_MODE)
            |-> (ba[0] == 1'b0 && addr[ADDR_W-1:7] == '0)); // R5

    AST_MAIN_WORD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == CMD_MODE && ba == BA_MAIN)
            |-> (addr[2:0] inside {3'b001, 3'b010, 3'b011}
                 && addr[6:4] inside {3'b010, 3'b011})); // R8

    AST_EXT_WORD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == CMD_MODE && ba == BA_EXT)
            |-> (addr[2:0] inside {3'b000, 3'b001, 3'b010, 3'b101, 3'b110})); // R8

    AST_MODE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == CMD_MODE)
            |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP)); // R6

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !start) |=> init_done); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP && addr == '0)); // R7

    AST_RESTART_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done) |-> ({cs_n, ras_n, cas_n, we_n} == CMD_DESL)); // R10

endmodule

// File: tb/tb_dram_init_seq.sv
module tb_dram_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD_PS  = CLK_PERIOD * 1000;
    localparam int PWR_NS     = 1000;
    localparam int NREF       = 2;
    localparam int AW         = 13;
    // R12: ceiling conversion computed here from the requirement
    localparam int P_CYC    = (PWR_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int RP_CYC   = (30 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int RFC_CYC  = (110 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int MRD_CYC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] cfg_bl = 3'b011;
    logic       cfg_wrap = 1'b1;
    logic [2:0] cfg_cl = 3'b010;
    logic [2:0] cfg_pasr = 3'b101;
    logic [1:0] cfg_tcsr = 2'b01;
    logic [1:0] cfg_drive = 2'b10;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done, config_error;
    logic [1:0] ba;
    logic [AW-1:0] addr;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_init_seq #(
        .CLK_PERIOD_PS (PERIOD_PS),
        .POWERUP_NS    (PWR_NS),
        .NUM_REFRESH   (NREF),
        .ADDR_W        (AW)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start (start),
        .cfg_burst_len (cfg_bl), .cfg_wrap (cfg_wrap), .cfg_cas_lat (cfg_cl),
        .cfg_pasr (cfg_pasr), .cfg_tcsr (cfg_tcsr), .cfg_drive (cfg_drive),
        .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .init_done (init_done), .config_error (config_error)
    );

    // ---------------- behavioural reference model ----------------
    int ev_t[$];
    int ev_k[$];
    int m_cnt = 0;
    bit m_done = 1'b0;
    bit m_err = 1'b0;
    bit chk_en = 1'b0;
    logic [AW-1:0] m_main = '0, m_ext = '0;
    logic [3:0] x_cmd = 4'b1111;
    logic [1:0] x_ba = 2'b00;
    logic [AW-1:0] x_addr = '0;
    string x_tag = "R1";
    bit restarted = 1'b0;

    function automatic logic [AW-1:0] ref_main(input logic [2:0] bl, input logic wr,
                                                input logic [2:0] cl);
        logic [2:0] b, c;
        b = (bl == 3'd1 || bl == 3'd2 || bl == 3'd3) ? bl : 3'd2;
        c = (cl == 3'd2 || cl == 3'd3) ? cl : 3'd3;
        return AW'({c, wr, b});
    endfunction

    function automatic logic [AW-1:0] ref_ext(input logic [2:0] pa, input logic [1:0] tc,
                                               input logic [1:0] dr);
        logic [2:0] p;
        p = (pa == 3'd0 || pa == 3'd1 || pa == 3'd2 || pa == 3'd5 || pa == 3'd6) ? pa : 3'd0;
        return AW'({dr, tc, p});
    endfunction

    function automatic bit ref_bad(input logic [2:0] bl, input logic [2:0] cl,
                                   input logic [2:0] pa);
        return !(bl inside {3'd1, 3'd2, 3'd3}) || !(cl inside {3'd2, 3'd3})
               || !(pa inside {3'd0, 3'd1, 3'd2, 3'd5, 3'd6});
    endfunction

    task automatic build_plan();
        int t;
        ev_t.delete();
        ev_k.delete();
        t = P_CYC;
        ev_t.push_back(t); ev_k.push_back(1);
        t += RP_CYC;
        for (int i = 0; i < NREF; i++) begin
            ev_t.push_back(t); ev_k.push_back(2);
            t += RFC_CYC;
        end
        ev_t.push_back(t); ev_k.push_back(3);
        t += MRD_CYC;
        ev_t.push_back(t); ev_k.push_back(4);
        t += MRD_CYC;
        ev_t.push_back(t); ev_k.push_back(5);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_err = 0; chk_en = 0;
            build_plan();
            x_cmd = 4'b1111; x_ba = 0; x_addr = '0; x_tag = "R1";
        end else begin
            chk_en = 1;
            x_ba = 0; x_addr = '0;
            if (m_done && start) begin
                m_cnt = 0; m_done = 0; restarted = 1;
                build_plan();
                x_cmd = 4'b1111; x_tag = "R10";
            end else begin
                m_cnt++;
                if (m_done) begin
                    x_cmd = 4'b0111; x_tag = "R7";
                end else if (m_cnt < P_CYC) begin
                    x_cmd = 4'b1111; x_tag = restarted ? "R10" : "R2";
                end else begin
                    x_cmd = 4'b0111; x_tag = "R3";
                end
                if (ev_t.size() > 0 && ev_t[0] == m_cnt) begin
                    int k;
                    k = ev_k[0];
                    void'(ev_t.pop_front());
                    void'(ev_k.pop_front());
                    case (k)
                        1: begin
                            x_cmd = 4'b0010; x_addr[10] = 1'b1; x_tag = "R2";
                            m_main = ref_main(cfg_bl, cfg_wrap, cfg_cl);
                            m_ext  = ref_ext(cfg_pasr, cfg_tcsr, cfg_drive);
                            m_err  = ref_bad(cfg_bl, cfg_cl, cfg_pasr);
                        end
                        2: begin x_cmd = 4'b0001; x_tag = "R4"; end
                        3: begin x_cmd = 4'b0000; x_ba = 2'b00; x_addr = m_main; x_tag = "R5 R9"; end
                        4: begin x_cmd = 4'b0000; x_ba = 2'b10; x_addr = m_ext; x_tag = "R6 R9"; end
                        default: begin x_cmd = 4'b0111; m_done = 1; x_tag = "R7"; end
                    endcase
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            check({cs_n, ras_n, cas_n, we_n} == x_cmd, x_tag, "cmd",
                  32'({cs_n, ras_n, cas_n, we_n}), 32'(x_cmd));
            check(ba == x_ba && addr == x_addr, x_tag, "ba/addr",
                  32'({ba, addr}), 32'({x_ba, x_addr}));
            check(init_done == m_done, "R7", "init_done", 32'(init_done), 32'(m_done));
            check(config_error == m_err, "R8", "config_error", 32'(config_error), 32'(m_err));
            check(cke == 1'b1, "R11", "cke", 32'(cke), 32'd1);
        end
    end

    task automatic wait_done();
        int n;
        n = 0;
        while (!init_done && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cke && cs_n && ras_n && cas_n && we_n, "R1", "bus in reset",
              32'({cke, cs_n, ras_n, cas_n, we_n}), 32'h1f);
        check(ba == 0 && addr == 0, "R1", "addr in reset", 32'({ba, addr}), 0);
        check(!init_done && !config_error, "R1", "flags in reset",
              32'({init_done, config_error}), 0);
        rst_n = 1'b1;
        // run 1: legal config; start mid-run must be ignored (R10)
        repeat (P_CYC + 5) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        repeat (6) @(negedge clk);
        // run 2: reserved codes replaced (R8)
        cfg_bl = 3'b000; cfg_cl = 3'b101; cfg_pasr = 3'b111;
        cfg_wrap = 1'b0; cfg_tcsr = 2'b11; cfg_drive = 2'b01;
        pulse_start();
        wait_done();
        repeat (4) @(negedge clk);
        // run 3: legal config; change after precharge is not seen (R9)
        cfg_bl = 3'b001; cfg_cl = 3'b011; cfg_pasr = 3'b010;
        cfg_tcsr = 2'b10; cfg_drive = 2'b00; cfg_wrap = 1'b1;
        pulse_start();
        repeat (P_CYC + 2) @(negedge clk);
        cfg_bl = 3'b110; cfg_cl = 3'b000; cfg_pasr = 3'b100; cfg_drive = 2'b11;
        wait_done();
        repeat (5) @(negedge clk);
        check(init_done == 1'b1, "R7", "final done", 32'(init_done), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule